// File: doc/BRIEF.md
# Flash Command and Interrupt Register Bank

This block is the host-facing register bank of a NAND-style flash controller. A 16-bit register bus (address, write enable, write data, combinational read data) gives the host access to six registers: command, two system configuration words, controller status, interrupt status and start-buffer. The bank decides whether a command write is accepted. It passes each accepted engine opcode on through a one-cycle strobe. It also collects completion reports from the execution engine and drives the interrupt and ready pins.

Each accepted command value is sorted into one of three decode classes. ENGINE covers the recognised flash operations and raises the strobe. RESET covers the two hot-reset opcodes, which restore the hot reset values. UNKNOWN covers every other value, which is flagged as a command error. The only gate on acceptance is the interrupt master bit. The bank has two reset paths. The active-low `rst_n` gives cold values. The synchronous `warm_rst` pin and the reset opcodes give hot values. Completion reports are folded in during the same cycle as any register write or hot reset, so neither update is lost.

Top module: `fcmd_regbank`

Register map (`reg_addr`): 0 command, 1 configuration A, 2 configuration B, 3 status, 4 interrupt, 5 start-buffer. All other addresses are unmapped.

## Requirements
- R1: After cold reset: command reads 0x0000, configuration A reads 0x40C0, configuration B reads 0, status reads 0, interrupt reads 0x8080, start-buffer reads 0x0000, `rdy_pin` is 1.
- R2: A hot reset restores the R1 values, except that the interrupt reads 0x8010. A hot reset is either `warm_rst` high at a clock edge or an accepted command of 0x00F0 or 0x00F3. A hot reset raises no strobe, and any register write in the same cycle is dropped.
- R3: A command write while interrupt bit 15 is 1 is ignored. The command register keeps its value and no strobe follows.
- R4: An accepted engine opcode is latched into the command register. `cmd_strobe` is high for the cycle after the write edge, with `cmd_op` showing the opcode. Engine opcodes are 0x0000, 0x0013, 0x0080, 0x001A, 0x001B, 0x0023, 0x0027, 0x002A, 0x002C, 0x0071, 0x0094, 0x0095, 0x00B0, 0x0030 and 0x0065.
- R5: An accepted command of any other value sets status bit 10 and interrupt bit 15, and raises no strobe.
- R6: An interrupt write ANDs the written value into the register. If bit 15 is 0 afterwards, status bits 10 to 13 are cleared; otherwise status is kept.
- R7: A completion (`done_valid`) ORs interrupt bit 15 into the interrupt register, plus a bit chosen by `done_kind`: 0 plain (none), 1 load (bit 7), 2 program (bit 6), 3 erase (bit 5). With `done_err`, status gains bit 10, plus bit 13 for load, bit 12 for program or bit 11 for erase.
- R8: A completion in the same cycle as a command write or an interrupt write keeps both effects. The completion bits are ORed after the write's own update.
- R9: `irq_pin` equals interrupt bit 15 when configuration A bit 6 is 1, and its inverse when that bit is 0.
- R10: `rdy_pin` takes bit 7 of each value written to configuration A, and is set to 1 by any reset.
- R11: Configuration A reads back with bits 4:0 forced to zero. Configuration B reads back exactly as written.
- R12: A start-buffer write stores a buffer index from bits 11:8 and a count from bits 1:0, where 0 means 4. The register reads back the index in bits 11:8 and bit 1 of (count-1) in bit 1, with all other bits zero.
- R13: Reads of unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst | input | 1 | Synchronous hot reset request |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| cmd_strobe | output | 1 | One-cycle start pulse to the execution engine |
| cmd_op | output | 16 | Latched command opcode |
| done_valid | input | 1 | Engine completion report |
| done_kind | input | 2 | Completion type: 0 plain, 1 load, 2 program, 3 erase |
| done_err | input | 1 | Completion ended in error |
| irq_pin | output | 1 | Interrupt pin, polarity set by configuration A bit 6 |
| rdy_pin | output | 1 | Ready pin |

## Verification
The hardest situations to reach are the same-cycle collisions. Examples are a completion landing on the same edge as a command write, and a completion landing on the same edge as an interrupt AND-mask that drops bit 15 and so wipes the status errors. The bench drives `done_valid` and `reg_we` on the same falling edge, which makes both land on one rising edge. It then reads back the interrupt and status words to show that the mask, the wipe and the completion bits all took effect in the defined order. Refusal under a pending interrupt is reached by first issuing an unknown opcode, which sets the master bit without any engine involvement.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
    localparam int DW   = 16;
    localparam int AW   = 4;

    localparam logic [AW-1:0] A_CMD  = 4'h0;
    localparam logic [AW-1:0] A_CFGA = 4'h1;
    localparam logic [AW-1:0] A_CFGB = 4'h2;
    localparam logic [AW-1:0] A_STAT = 4'h3;
    localparam logic [AW-1:0] A_INTR = 4'h4;
    localparam logic [AW-1:0] A_SBUF = 4'h5;

    // interrupt register bit positions
    localparam int IB_MASTER = 15;
    localparam int IB_RST    = 4;
    localparam int IB_ERASE  = 5;
    localparam int IB_PROG   = 6;
    localparam int IB_LOAD   = 7;
    // status register bit positions
    localparam int SB_CMD    = 10;
    localparam int SB_ERASE  = 11;
    localparam int SB_PROG   = 12;
    localparam int SB_LOAD   = 13;
    localparam logic [DW-1:0] ERR_MASK =
        DW'((1 << SB_CMD) | (1 << SB_ERASE) | (1 << SB_PROG) | (1 << SB_LOAD));

    localparam logic [DW-1:0] CFGA_RST  = 16'h40C0;
    localparam logic [DW-1:0] INTR_COLD = 16'h8080;
    localparam logic [DW-1:0] INTR_HOT  = 16'h8010;
    localparam logic [DW-1:0] CFGA_RDMASK = 16'hFFE0;
    localparam int CFG_IRQPOL = 6;
    localparam int CFG_RDY    = 7;

    localparam int SBUF_IDX_LSB = 8;
    localparam int SBUF_IDX_W   = 4;
    localparam int SBUF_CNT_W   = 3;

    typedef enum logic [1:0] {
        CLS_UNKNOWN = 2'd0,
        CLS_RESET   = 2'd1,
        CLS_ENGINE  = 2'd2
    } cmd_class_e;

    typedef enum logic [1:0] {
        DONE_PLAIN = 2'd0,
        DONE_LOAD  = 2'd1,
        DONE_PROG  = 2'd2,
        DONE_ERASE = 2'd3
    } done_kind_e;

    function automatic cmd_class_e classify(input logic [DW-1:0] op);
        cmd_class_e c;
        unique case (op)
            16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
            16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
            16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065: c = CLS_ENGINE;
            16'h00F0, 16'h00F3:                               c = CLS_RESET;
            default:                                          c = CLS_UNKNOWN;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import fcmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          cmd_we,
    input  logic [DW-1:0] wdata,
    input  logic          intr_master,
    output logic [DW-1:0] cmd_q,
    output logic          cmd_strobe,
    output logic          unknown_hit,
    output logic          hot_rst
);
    cmd_class_e cls;
    logic       accept;

    always_comb begin
        cls         = classify(wdata);
        accept      = cmd_we && !intr_master;
        unknown_hit = accept && (cls == CLS_UNKNOWN) && !warm_rst;
        hot_rst     = warm_rst || (accept && (cls == CLS_RESET));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            cmd_strobe <= 1'b0;
        end else if (hot_rst) begin
            cmd_q      <= '0;
            cmd_strobe <= 1'b0;
        end else begin
            cmd_strobe <= accept && (cls == CLS_ENGINE);
            if (accept) cmd_q <= wdata;
        end
    end

    assert_refuse_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && intr_master && !warm_rst) |=> ($stable(cmd_q) && !cmd_strobe));

    assert_strobe_engine_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> (classify(cmd_q) == CLS_ENGINE));
endmodule

// File: rtl/fcmd_intr_ctrl.sv
module fcmd_intr_ctrl
    import fcmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hot_rst,
    input  logic          intr_we,
    input  logic [DW-1:0] wdata,
    input  logic          unknown_hit,
    input  logic          done_valid,
    input  logic [1:0]    done_kind,
    input  logic          done_err,
    output logic [DW-1:0] intr_q,
    output logic [DW-1:0] stat_q
);
    logic [DW-1:0] intr_base, stat_base, intr_set, stat_set, masked;
    done_kind_e    kind;

    always_comb begin
        kind   = done_kind_e'(done_kind);
        masked = intr_q & wdata;
        if (hot_rst) begin
            intr_base = INTR_HOT;
            stat_base = '0;
        end else if (intr_we) begin
            intr_base = masked;
            stat_base = masked[IB_MASTER] ? stat_q : (stat_q & ~ERR_MASK);
        end else begin
            intr_base = intr_q;
            stat_base = stat_q;
        end

        intr_set = '0;
        stat_set = '0;
        if (unknown_hit) begin
            intr_set[IB_MASTER] = 1'b1;
            stat_set[SB_CMD]    = 1'b1;
        end
        if (done_valid) begin
            intr_set[IB_MASTER] = 1'b1;
            if (done_err) stat_set[SB_CMD] = 1'b1;
            unique case (kind)
                DONE_PLAIN: ;
                DONE_LOAD: begin
                    intr_set[IB_LOAD] = 1'b1;
                    if (done_err) stat_set[SB_LOAD] = 1'b1;
                end
                DONE_PROG: begin
                    intr_set[IB_PROG] = 1'b1;
                    if (done_err) stat_set[SB_PROG] = 1'b1;
                end
                DONE_ERASE: begin
                    intr_set[IB_ERASE] = 1'b1;
                    if (done_err) stat_set[SB_ERASE] = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intr_q <= INTR_COLD;
            stat_q <= '0;
        end else begin
            intr_q <= intr_base | intr_set;
            stat_q <= stat_base | stat_set;
        end
    end

    assert_done_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> intr_q[IB_MASTER]);

    assert_err_wipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_we && !hot_rst && !done_valid && !(intr_q[IB_MASTER] && wdata[IB_MASTER]))
        |=> ((stat_q & ERR_MASK) == '0));
endmodule

// File: rtl/fcmd_cfg_regs.sv
module fcmd_cfg_regs
    import fcmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hot_rst,
    input  logic          cfga_we,
    input  logic          cfgb_we,
    input  logic          sbuf_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfga_q,
    output logic [DW-1:0] cfgb_q,
    output logic          rdy_q,
    output logic [DW-1:0] sbuf_rd
);
    logic [SBUF_IDX_W-1:0] idx_q;
    logic [SBUF_CNT_W-1:0] cnt_q, cnt_d;
    logic                  cnt_hi;

    always_comb begin
        cnt_d   = (wdata[1:0] == 2'd0) ? SBUF_CNT_W'(4) : SBUF_CNT_W'(wdata[1:0]);
        cnt_hi  = (cnt_q == SBUF_CNT_W'(3)) || (cnt_q == SBUF_CNT_W'(4));
        sbuf_rd = '0;
        sbuf_rd[SBUF_IDX_LSB +: SBUF_IDX_W] = idx_q;
        sbuf_rd[1] = cnt_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfga_q <= CFGA_RST;
            cfgb_q <= '0;
            rdy_q  <= 1'b1;
            idx_q  <= '0;
            cnt_q  <= SBUF_CNT_W'(1);
        end else if (hot_rst) begin
            cfga_q <= CFGA_RST;
            cfgb_q <= '0;
            rdy_q  <= 1'b1;
            idx_q  <= '0;
            cnt_q  <= SBUF_CNT_W'(1);
        end else begin
            if (cfga_we) begin
                cfga_q <= wdata;
                rdy_q  <= wdata[CFG_RDY];
            end
            if (cfgb_we) cfgb_q <= wdata;
            if (sbuf_we) begin
                idx_q <= wdata[SBUF_IDX_LSB +: SBUF_IDX_W];
                cnt_q <= cnt_d;
            end
        end
    end

    assert_rdy_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfga_we && !hot_rst) |=> (rdy_q == $past(wdata[CFG_RDY])));

    assert_hot_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hot_rst |=> ((cfga_q == CFGA_RST) && rdy_q && (cfgb_q == '0)));
endmodule

// File: rtl/fcmd_regbank.sv
module fcmd_regbank
    import fcmd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          cmd_strobe,
    output logic [DW-1:0] cmd_op,
    input  logic          done_valid,
    input  logic [1:0]    done_kind,
    input  logic          done_err,
    output logic          irq_pin,
    output logic          rdy_pin
);
    logic          we_cmd, we_cfga, we_cfgb, we_intr, we_sbuf;
    logic          unknown_hit, hot_rst;
    logic [DW-1:0] cmd_q, cfga_q, cfgb_q, intr_q, stat_q, sbuf_rd;

    always_comb begin
        we_cmd  = reg_we && (reg_addr == A_CMD);
        we_cfga = reg_we && (reg_addr == A_CFGA);
        we_cfgb = reg_we && (reg_addr == A_CFGB);
        we_intr = reg_we && (reg_addr == A_INTR);
        we_sbuf = reg_we && (reg_addr == A_SBUF);
    end

    fcmd_decode u_decode (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .cmd_we(we_cmd), .wdata(reg_wdata), .intr_master(intr_q[IB_MASTER]),
        .cmd_q(cmd_q), .cmd_strobe(cmd_strobe),
        .unknown_hit(unknown_hit), .hot_rst(hot_rst)
    );

    fcmd_intr_ctrl u_intr (
        .clk(clk), .rst_n(rst_n), .hot_rst(hot_rst),
        .intr_we(we_intr), .wdata(reg_wdata), .unknown_hit(unknown_hit),
        .done_valid(done_valid), .done_kind(done_kind), .done_err(done_err),
        .intr_q(intr_q), .stat_q(stat_q)
    );

    fcmd_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .hot_rst(hot_rst),
        .cfga_we(we_cfga), .cfgb_we(we_cfgb), .sbuf_we(we_sbuf),
        .wdata(reg_wdata), .cfga_q(cfga_q), .cfgb_q(cfgb_q),
        .rdy_q(rdy_pin), .sbuf_rd(sbuf_rd)
    );

    assign cmd_op  = cmd_q;
    assign irq_pin = intr_q[IB_MASTER] ~^ cfga_q[CFG_IRQPOL];

    always_comb begin
        case (reg_addr)
            A_CMD:   reg_rdata = cmd_q;
            A_CFGA:  reg_rdata = cfga_q & CFGA_RDMASK;
            A_CFGB:  reg_rdata = cfgb_q;
            A_STAT:  reg_rdata = stat_q;
            A_INTR:  reg_rdata = intr_q;
            A_SBUF:  reg_rdata = sbuf_rd;
            default: reg_rdata = '0;
        endcase
    end

    assert_unknown_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        unknown_hit |=> (stat_q[SB_CMD] && intr_q[IB_MASTER] && !cmd_strobe));
endmodule

// File: tb/fcmd_regbank_test.sv
module fcmd_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cmd_strobe;
    logic [15:0] cmd_op;
    logic        done_valid = 1'b0;
    logic [1:0]  done_kind = '0;
    logic        done_err = 1'b0;
    logic        irq_pin, rdy_pin;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fcmd_regbank uut (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmd_strobe(cmd_strobe), .cmd_op(cmd_op),
        .done_valid(done_valid), .done_kind(done_kind), .done_err(done_err),
        .irq_pin(irq_pin), .rdy_pin(rdy_pin)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  waddr;
        logic [15:0] wdata;
        logic [3:0]  raddr;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'h4, 16'h0000, 4'h4, 16'h0000, 4'd6 },  // R6 clear pending
        '{1'b1, 4'h1, 16'h1234, 4'h1, 16'h1220, 4'd11},  // R11 low bits masked
        '{1'b1, 4'h2, 16'hBEEF, 4'h2, 16'hBEEF, 4'd11},  // R11 full readback
        '{1'b1, 4'h5, 16'h0A02, 4'h5, 16'h0A00, 4'd12},  // R12 count 2
        '{1'b1, 4'h5, 16'h0F00, 4'h5, 16'h0F02, 4'd12},  // R12 count 4
        '{1'b1, 4'h5, 16'h0303, 4'h5, 16'h0302, 4'd12},  // R12 count 3
        '{1'b1, 4'h0, 16'h00AB, 4'h3, 16'h0400, 4'd5 },  // R5 unknown opcode
        '{1'b0, 4'h0, 16'h0000, 4'h4, 16'h8000, 4'd5 },  // R5 master set
        '{1'b1, 4'h0, 16'h0094, 4'h0, 16'h00AB, 4'd3 },  // R3 refused
        '{1'b1, 4'h4, 16'hFFFF, 4'h3, 16'h0400, 4'd6 },  // R6 errors kept
        '{1'b1, 4'h4, 16'h7FFF, 4'h3, 16'h0000, 4'd6 },  // R6 errors wiped
        '{1'b1, 4'hF, 16'hFFFF, 4'hF, 16'h0000, 4'd13},  // R13 unmapped read
        '{1'b0, 4'h0, 16'h0000, 4'h2, 16'hBEEF, 4'd13}   // R13 write no effect
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a; reg_we = 1'b0;
        #1;
        d = reg_rdata;
    endtask

    task automatic done(input logic [1:0] k, input logic e);
        @(negedge clk);
        done_valid = 1'b1; done_kind = k; done_err = e;
        @(negedge clk);
        done_valid = 1'b0; done_err = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 cold reset values
        rd(4'h0, v); chk("R1 command", v, 16'h0000);
        rd(4'h1, v); chk("R1 cfgA", v, 16'h40C0);
        rd(4'h2, v); chk("R1 cfgB", v, 16'h0000);
        rd(4'h3, v); chk("R1 status", v, 16'h0000);
        rd(4'h4, v); chk("R1 interrupt", v, 16'h8080);
        rd(4'h5, v); chk("R1 sbuf", v, 16'h0000);
        chk("R1 rdy", {15'b0, rdy_pin}, 16'h1);
        chk("R9 irq active-high pending", {15'b0, irq_pin}, 16'h1);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) wr(VEC[i].waddr, VEC[i].wdata);
            else @(negedge clk);
            rd(VEC[i].raddr, v);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
        end

        // R9 cfgA bit6 = 0, master clear -> pin high
        chk("R9 inverted idle", {15'b0, irq_pin}, 16'h1);

        // R4 engine command
        wr(4'h0, 16'h0080);
        chk("R4 strobe", {15'b0, cmd_strobe}, 16'h1);
        chk("R4 opcode", cmd_op, 16'h0080);
        @(negedge clk);
        chk("R4 strobe single", {15'b0, cmd_strobe}, 16'h0);

        // R7 program completion with error
        done(2'd2, 1'b1);
        rd(4'h4, v); chk("R7 intr prog", v, 16'h8040);
        rd(4'h3, v); chk("R7 stat prog err", v, 16'h1400);
        chk("R9 inverted pending", {15'b0, irq_pin}, 16'h0);

        // R10 ready follows cfgA bit 7, R9 polarity flip
        wr(4'h1, 16'h00C0);
        chk("R10 rdy high", {15'b0, rdy_pin}, 16'h1);
        chk("R9 active-high pending", {15'b0, irq_pin}, 16'h1);
        wr(4'h1, 16'h0040);
        chk("R10 rdy low", {15'b0, rdy_pin}, 16'h0);

        // clear
        wr(4'h4, 16'h0000);
        rd(4'h3, v); chk("R6 wipe after clear", v, 16'h0000);

        // R8 command write + load completion in one cycle
        @(negedge clk);
        reg_addr = 4'h0; reg_wdata = 16'h0094; reg_we = 1'b1;
        done_valid = 1'b1; done_kind = 2'd1; done_err = 1'b0;
        @(negedge clk);
        reg_we = 1'b0; done_valid = 1'b0;
        chk("R8 strobe kept", {15'b0, cmd_strobe}, 16'h1);
        chk("R8 opcode kept", cmd_op, 16'h0094);
        rd(4'h4, v); chk("R8 intr load", v, 16'h8080);

        // R8 interrupt mask + erase error completion in one cycle
        @(negedge clk);
        reg_addr = 4'h4; reg_wdata = 16'h7FFF; reg_we = 1'b1;
        done_valid = 1'b1; done_kind = 2'd3; done_err = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; done_valid = 1'b0; done_err = 1'b0;
        rd(4'h4, v); chk("R8 intr mask+erase", v, 16'h80A0);
        rd(4'h3, v); chk("R8 stat erase err", v, 16'h0C00);

        // R2 hot reset by opcode
        wr(4'h4, 16'h0000);
        wr(4'h0, 16'h00F3);
        chk("R2 no strobe", {15'b0, cmd_strobe}, 16'h0);
        rd(4'h4, v); chk("R2 intr hot", v, 16'h8010);
        rd(4'h0, v); chk("R2 command", v, 16'h0000);
        rd(4'h1, v); chk("R2 cfgA", v, 16'h40C0);
        rd(4'h3, v); chk("R2 status", v, 16'h0000);
        chk("R2 rdy", {15'b0, rdy_pin}, 16'h1);

        // R2 warm reset pin
        wr(4'h2, 16'h55AA);
        wr(4'h4, 16'h0000);
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
        rd(4'h2, v); chk("R2 warm cfgB", v, 16'h0000);
        rd(4'h4, v); chk("R2 warm intr", v, 16'h8010);

        // R7 plain completion with error
        wr(4'h4, 16'h0000);
        done(2'd0, 1'b1);
        rd(4'h4, v); chk("R7 intr plain", v, 16'h8000);
        rd(4'h3, v); chk("R7 stat plain err", v, 16'h0400);

        summary();
    end
endmodule